// File: doc/BRIEF.md
# Canceling Delay-Slot Branch Controller

This block steers instruction fetch for a pipeline in which every conditional branch is followed by exactly one delay slot. The fetch stage flags each branch it decodes, together with whether the branch is of the canceling kind and which direction the compiler statically predicted. The controller then fetches the delay-slot instruction and holds the fetch address for two bubble cycles while the condition is evaluated late in execute. After that it redirects fetch to the branch target or to the sequential fall-through address.

The resolved outcome and target arrive from the execute stage in the second bubble cycle. An ordinary delayed branch always lets its slot instruction commit. A canceling branch whose real outcome disagrees with its static prediction raises a kill strobe in the resolve cycle. That strobe turns the slot instruction into a no-op before it writes any architectural state. A branch decoded inside a delay slot is illegal: the block flags it and does not track it.

Top module: `dslot_branch_ctrl`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `fetchPc` equals the reset vector (default 0x0000_1000), `stall`, `slotKill` and `slotIllegal` are 0, and `nextPcSel` is 0. With no branch flagged, `fetchPc` advances by 4 on every clock edge.
- R2: If `brValid` is high in a cycle with fetch address B and no branch is in flight, the next cycle fetches the delay slot at B+4 with `stall` low.
- R3: The two cycles that follow the slot cycle have `stall` high and `fetchPc` held at B+4. `nextPcSel` is 1 (hold) in the slot cycle and in the first of these two cycles.
- R4: A resolution (`resValid` high) in the second stall cycle redirects fetch. On the next edge `fetchPc` becomes `resTarget` if `resTaken` is 1 and B+8 otherwise. In the resolve cycle `nextPcSel` is 2 (target) or 0 (sequential) accordingly.
- R5: If `resValid` is low in the second stall cycle, the block stays in that cycle. `stall` stays high and `fetchPc` stays at B+4 until a resolution arrives.
- R6: For an ordinary branch (`brLikely` 0), `slotKill` is never asserted, whatever the outcome.
- R7: For a canceling branch (`brLikely` 1), `slotKill` is high during the resolve cycle exactly when `resTaken` differs from the captured `brPredTaken`. It is low in every other cycle.
- R8: `brValid` during the slot cycle raises `slotIllegal` in that cycle. The second branch is not tracked, and the fetch timeline of the first branch is unchanged.
- R9: `resValid` outside the second stall cycle has no effect. `fetchPc` keeps its normal progression and `slotKill` stays 0.
- R10: `brValid` during either stall cycle is ignored. It neither starts tracking nor changes `fetchPc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| brValid | input | 1 | The instruction at `fetchPc` is a conditional branch |
| brLikely | input | 1 | That branch is of the canceling kind |
| brPredTaken | input | 1 | Static predicted direction of the canceling branch |
| resValid | input | 1 | Execute stage presents the branch outcome |
| resTaken | input | 1 | Resolved outcome, 1 = taken |
| resTarget | input | ADDR_W | Resolved branch target address |
| fetchPc | output | ADDR_W | Current fetch address |
| nextPcSel | output | 2 | Next-PC source: 0 sequential, 1 hold, 2 target |
| stall | output | 1 | Fetch bubble request |
| slotKill | output | 1 | Squash the tracked delay-slot instruction |
| slotIllegal | output | 1 | A branch was decoded inside a delay slot |

## Verification
`fetchPc` reacts one edge after its cause, so the slot address is checked one cycle after `brValid`. The redirected address is checked one cycle after the resolve cycle. `stall`, `slotKill`, `slotIllegal` and `nextPcSel` are combinational from state and inputs and are checked in the same cycle as the stimulus that causes them. The bench drives inputs just after a rising edge, samples outputs a short delay later and well before the next edge, and lines up every expected value with the cycle count counted from the branch cycle.

// File: rtl/dslot_branch_pkg.sv
package dslot_branch_pkg;

  typedef enum logic [1:0] {
    SEL_SEQ    = 2'd0,
    SEL_HOLD   = 2'd1,
    SEL_TARGET = 2'd2
  } pcSel_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SLOT  = 2'd1,
    ST_WAIT1 = 2'd2,
    ST_WAIT2 = 2'd3
  } brState_e;

  typedef struct packed {
    logic hold;
    logic useTarget;
  } pcCtl_t;

endpackage

// File: rtl/dslot_branch_fsm.sv
module dslot_branch_fsm
  import dslot_branch_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   brValid,
  input  logic   brLikely,
  input  logic   brPredTaken,
  input  logic   resValid,
  input  logic   resTaken,
  output pcCtl_t ctl,
  output pcSel_e sel,
  output logic   stall,
  output logic   slotKill,
  output logic   slotIllegal
);

  brState_e stateQ, stateD;
  logic     likelyQ, predQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ  <= ST_IDLE;
      likelyQ <= 1'b0;
      predQ   <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (stateQ == ST_IDLE && brValid) begin
        likelyQ <= brLikely;
        predQ   <= brPredTaken;
      end
    end
  end

  always_comb begin
    stateD      = stateQ;
    sel         = SEL_SEQ;
    stall       = 1'b0;
    slotKill    = 1'b0;
    slotIllegal = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (brValid) stateD = ST_SLOT;
      end
      ST_SLOT: begin
        sel         = SEL_HOLD;
        slotIllegal = brValid;
        stateD      = ST_WAIT1;
      end
      ST_WAIT1: begin
        stall  = 1'b1;
        sel    = SEL_HOLD;
        stateD = ST_WAIT2;
      end
      ST_WAIT2: begin
        stall = 1'b1;
        if (resValid) begin
          sel      = resTaken ? SEL_TARGET : SEL_SEQ;
          slotKill = likelyQ && (resTaken != predQ);
          stateD   = ST_IDLE;
        end else begin
          sel = SEL_HOLD;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  assign ctl.hold      = (sel == SEL_HOLD);
  assign ctl.useTarget = (sel == SEL_TARGET);

  AST_KILL_IN_STALL: assert property (@(posedge clk) disable iff (rst)
    slotKill |-> (stall && resValid)) else $error("kill outside resolve"); // R7
  AST_ORDINARY_NO_KILL: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_SLOT && !likelyQ) |=> !slotKill ##1 !slotKill ##1 !slotKill)
    else $error("ordinary branch killed slot"); // R6
  AST_SLOT_THEN_STALL: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_IDLE && brValid) |=> !stall ##1 stall ##1 stall)
    else $error("stall timing"); // R3
  AST_ILLEGAL_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    slotIllegal |-> (!stall && sel == SEL_HOLD)) else $error("illegal flag"); // R8
  AST_WAIT_PERSIST: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_WAIT2 && !resValid) |=> stall) else $error("wait dropped"); // R5

endmodule

// File: rtl/dslot_branch_pcpath.sv
module dslot_branch_pcpath
  import dslot_branch_pkg::*;
#(
  parameter int unsigned             ADDR_W      = 32,
  parameter int unsigned             INSTR_BYTES = 4,
  parameter logic [ADDR_W-1:0]       RESET_VEC   = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst,
  input  pcCtl_t            ctl,
  input  logic [ADDR_W-1:0] resTarget,
  output logic [ADDR_W-1:0] fetchPc
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

  logic [ADDR_W-1:0] pcQ, pcInc, pcD;

  assign pcInc = pcQ + STEP;

  always_comb begin
    if (ctl.useTarget)  pcD = resTarget;
    else if (ctl.hold)  pcD = pcQ;
    else                pcD = pcInc;
  end

  always_ff @(posedge clk) begin
    if (rst) pcQ <= RESET_VEC;
    else     pcQ <= pcD;
  end

  assign fetchPc = pcQ;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    ctl.hold |=> $stable(pcQ)) else $error("pc moved during hold"); // R3
  AST_TARGET_LOAD: assert property (@(posedge clk) disable iff (rst)
    ctl.useTarget |=> (pcQ == $past(resTarget))) else $error("target not loaded"); // R4

endmodule

// File: rtl/dslot_branch_ctrl.sv
module dslot_branch_ctrl
  import dslot_branch_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 32,
  parameter int unsigned       INSTR_BYTES = 4,
  parameter logic [ADDR_W-1:0] RESET_VEC   = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              brValid,
  input  logic              brLikely,
  input  logic              brPredTaken,
  input  logic              resValid,
  input  logic              resTaken,
  input  logic [ADDR_W-1:0] resTarget,
  output logic [ADDR_W-1:0] fetchPc,
  output logic [1:0]        nextPcSel,
  output logic              stall,
  output logic              slotKill,
  output logic              slotIllegal
);

  pcCtl_t ctl;
  pcSel_e sel;

  dslot_branch_fsm uFsm (
    .clk         (clk),
    .rst         (rst),
    .brValid     (brValid),
    .brLikely    (brLikely),
    .brPredTaken (brPredTaken),
    .resValid    (resValid),
    .resTaken    (resTaken),
    .ctl         (ctl),
    .sel         (sel),
    .stall       (stall),
    .slotKill    (slotKill),
    .slotIllegal (slotIllegal)
  );

  dslot_branch_pcpath #(
    .ADDR_W      (ADDR_W),
    .INSTR_BYTES (INSTR_BYTES),
    .RESET_VEC   (RESET_VEC)
  ) uPath (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .resTarget (resTarget),
    .fetchPc   (fetchPc)
  );

  assign nextPcSel = sel;

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (!stall && nextPcSel == 2'd0) |=> (fetchPc == $past(fetchPc) + ADDR_W'(INSTR_BYTES)))
    else $error("sequential step wrong"); // R1

endmodule

// File: tb/tb_dslot_branch_ctrl.sv
`timescale 1ns/1ps
module tb_dslot_branch_ctrl;

  localparam int unsigned ADDR_W = 32;
  localparam logic [31:0] RVEC   = 32'h0000_1000;
  localparam int          NV     = 6;

  // per vector: likely, predicted taken, actual taken, target
  localparam logic        V_LIK [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1};
  localparam logic        V_PRD [NV] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
  localparam logic        V_TKN [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
  localparam logic [31:0] V_TGT [NV] = '{32'h0000_2000, 32'h0000_3000, 32'h0000_4400,
                                         32'h0000_5000, 32'h0000_6800, 32'h0000_7000};

  logic clk = 1'b0;
  logic rst, brValid, brLikely, brPredTaken, resValid, resTaken;
  logic [31:0] resTarget, fetchPc;
  logic [1:0]  nextPcSel;
  logic stall, slotKill, slotIllegal;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  dslot_branch_ctrl #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .brValid(brValid), .brLikely(brLikely),
    .brPredTaken(brPredTaken), .resValid(resValid), .resTaken(resTaken),
    .resTarget(resTarget), .fetchPc(fetchPc), .nextPcSel(nextPcSel),
    .stall(stall), .slotKill(slotKill), .slotIllegal(slotIllegal)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // advance one edge, then settle inputs-driven outputs
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic settle();
    #1;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] b, expPc;
    logic        expKill;
    rst = 1; brValid = 0; brLikely = 0; brPredTaken = 0;
    resValid = 0; resTaken = 0; resTarget = '0;
    step(); step();
    // R1: reset state
    chk("R1 pc in reset", fetchPc, RVEC);
    chk("R1 stall in reset", {31'b0, stall}, 0);
    chk("R1 sel in reset", {30'b0, nextPcSel}, 0);
    rst = 0;
    settle();
    chk("R1 pc after release", fetchPc, RVEC);
    step();
    chk("R1 increment", fetchPc, RVEC + 4);
    step();
    chk("R1 increment 2", fetchPc, RVEC + 8);

    // R9: resolution while idle ignored
    resValid = 1; resTaken = 1; resTarget = 32'hDEAD_0000;
    settle();
    chk("R9 no kill idle", {31'b0, slotKill}, 0);
    step();
    resValid = 0;
    chk("R9 pc unaffected", fetchPc, RVEC + 12);

    // table walk: R2 R3 R4 R6 R7
    for (int i = 0; i < NV; i++) begin
      b = fetchPc;
      expKill = V_LIK[i] && (V_TKN[i] != V_PRD[i]);
      expPc   = V_TKN[i] ? V_TGT[i] : b + 8;
      brValid = 1; brLikely = V_LIK[i]; brPredTaken = V_PRD[i];
      settle();
      chk("R2 no stall at branch", {31'b0, stall}, 0);
      step();
      brValid = 0; brLikely = 0; brPredTaken = ~V_PRD[i];
      settle();
      chk("R2 slot pc", fetchPc, b + 4);
      chk("R2 slot no stall", {31'b0, stall}, 0);
      chk("R3 slot sel hold", {30'b0, nextPcSel}, 1);
      step();
      chk("R3 stall1", {31'b0, stall}, 1);
      chk("R3 stall1 pc", fetchPc, b + 4);
      chk("R3 stall1 sel", {30'b0, nextPcSel}, 1);
      step();
      resValid = 1; resTaken = V_TKN[i]; resTarget = V_TGT[i];
      settle();
      chk("R3 stall2", {31'b0, stall}, 1);
      chk("R3 stall2 pc", fetchPc, b + 4);
      chk(V_LIK[i] ? "R7 kill" : "R6 kill", {31'b0, slotKill}, {31'b0, expKill});
      chk("R4 sel", {30'b0, nextPcSel}, V_TKN[i] ? 2 : 0);
      step();
      resValid = 0; resTarget = '0;
      settle();
      chk("R4 redirect pc", fetchPc, expPc);
      chk("R4 no stall after", {31'b0, stall}, 0);
      chk("R7 kill cleared", {31'b0, slotKill}, 0);
      step();
    end

    // R5 + R8 + R10 + R9: late resolve, branch in slot, branch in stall
    b = fetchPc;
    brValid = 1; brLikely = 1; brPredTaken = 1;
    step();
    // slot cycle: second branch (R8), stray resolve (R9)
    brValid = 1; brLikely = 0; brPredTaken = 0;
    resValid = 1; resTaken = 0; resTarget = 32'h0BAD_0000;
    settle();
    chk("R8 illegal flag", {31'b0, slotIllegal}, 1);
    chk("R9 no kill in slot", {31'b0, slotKill}, 0);
    step();
    brValid = 1; resValid = 0;
    settle();
    chk("R8 illegal cleared", {31'b0, slotIllegal}, 0);
    chk("R10 stall1 pc held", fetchPc, b + 4);
    step();
    brValid = 0;
    for (int k = 0; k < 3; k++) begin
      settle();
      chk("R5 still stalled", {31'b0, stall}, 1);
      chk("R5 pc held", fetchPc, b + 4);
      step();
    end
    resValid = 1; resTaken = 0; resTarget = 32'h0000_9000;
    settle();
    chk("R7 likely mispredict kill", {31'b0, slotKill}, 1);
    step();
    resValid = 0;
    settle();
    chk("R5 late not-taken pc", fetchPc, b + 8);
    chk("R10 no extra tracking", {31'b0, stall}, 0);
    step();
    chk("R10 sequential after", fetchPc, b + 12);

    // R1: reset mid-flight clears tracking
    brValid = 1;
    step();
    brValid = 0; rst = 1;
    step();
    rst = 0;
    settle();
    chk("R1 reset clears pc", fetchPc, RVEC);
    chk("R1 reset clears stall", {31'b0, stall}, 0);
    step();
    chk("R1 after reset step", fetchPc, RVEC + 4);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule